// File: doc/BRIEF.md
# Step Command Latch and Countdown

This block sits between a host that speaks over a parallel-port style interface and a stepper drive. The host places an 8-bit motion word on the data lines and strobes an enable. The block stores the word and arms itself. On the next falling edge of the step clock it copies the step count into a down-counter and raises a load acknowledge. That acknowledge stays up until the host answers with a clear strobe, so each command is loaded exactly once. The counter then steps down by one on every rising edge of the step clock. It emits a one-cycle step pulse per decrement and reports completion once it reaches zero.

The same block also relays two sensor signals. A drop-sensor event sets a sticky flag, which the host clears with its own strobe. A patient-ready push button is passed through. Both of these outputs are held low while reset is applied. Every register runs on one system clock with a synchronous active-high reset. All host and sensor lines, and the step clock, pass through a `SYNC_STAGES`-deep synchronizer. The block acts on the rising or falling edges of those lines, never on their levels.

Top module: `step_cmd_ctrl`

## Requirements
- R1: The command word carries the turn direction in bit 7 and an unsigned step count in bits 6:0 (0 to 127). `motor_dir` shows bit 7 of the most recently loaded word from the load cycle onward.
- R2: A rising edge on `cmd_strobe` captures `cmd_word` and arms the block. Without such a strobe, no load takes place, however many step-clock edges arrive.
- R3: When the block is armed and not yet acknowledged, the next falling edge of `step_clk` loads the count and raises `load_ack`. For a nonzero count, `run_done` falls in that same cycle.
- R4: A rising edge on `ack_clear` brings `load_ack` low.
- R5: While `load_ack` is high, the counter is never reloaded. A strobe that arrives during that time replaces the stored word, and that word is loaded at the first falling step-clock edge after the next `ack_clear` edge.
- R6: Each rising edge of `step_clk` while the count is nonzero gives exactly one `step_pulse` cycle and decrements the count by one. A command with count N therefore produces exactly N pulses, and no pulse occurs at zero.
- R7: `run_done` is high whenever the count is zero. A zero-count command still raises `load_ack`, but `run_done` stays high and no pulse is produced.
- R8: A rising edge on `drop_sense` sets `drop_flag`. The flag then stays high until a rising edge on `drop_clear`.
- R9: `drop_flag` and `patient_ready` are low in every cycle in which `rst` is high.
- R10: Outside reset, `patient_ready` follows `button` after the synchronizer delay.
- R11: After reset, `run_done` is 1 and `load_ack`, `step_pulse`, `motor_dir` and `drop_flag` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_word | input | CMD_W | Motion word: direction in the top bit, step count below it |
| cmd_strobe | input | 1 | Host enable; a rising edge captures `cmd_word` |
| ack_clear | input | 1 | Host strobe; a rising edge clears the load acknowledge |
| step_clk | input | 1 | Step clock; falling edge loads, rising edge decrements |
| drop_sense | input | 1 | Drop sensor line |
| drop_clear | input | 1 | Host strobe that clears the drop flag |
| button | input | 1 | Patient-ready push button |
| motor_dir | output | 1 | Direction of the loaded command |
| step_pulse | output | 1 | One-cycle pulse per step taken |
| load_ack | output | 1 | Count has been loaded; waits for `ack_clear` |
| run_done | output | 1 | Count is zero |
| drop_flag | output | 1 | Sticky drop event flag |
| patient_ready | output | 1 | Synchronized button state |

## Verification
If the arm or acknowledge state is wrong, it shows at the ports on the next falling step-clock edge. `load_ack` either fails to rise or rises a second time for the same command. A second rise pairs with no queued command, and a missing rise leaves a command stuck in the scoreboard. A wrong count only shows when the run ends: the pulse total between the rise of `load_ack` and the rise of `run_done` differs from the commanded count. For a full-scale command, that end comes up to 127 step periods later. A flag or gating fault in the sensor path appears within a few cycles of the stimulus. The bench observes these outputs during held idle windows and during reset.

// File: rtl/step_pkg.sv
package step_pkg;

  // Raw asynchronous lines gathered so they share one synchronizer
  typedef struct packed {
    logic cmd_strobe;
    logic ack_clear;
    logic step_clk;
    logic drop_sense;
    logic drop_clear;
    logic button;
  } host_in_t;

  localparam int HOST_IN_W = $bits(host_in_t);

endpackage

// File: rtl/sync_bits.sv
module sync_bits #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  if (STAGES == 0) begin : g_bypass
    assign q = d;
  end else begin : g_chain
    logic [STAGES-1:0][W-1:0] stg_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        stg_q <= '0;
      end else begin
        stg_q[0] <= d;
        for (int i = 1; i < STAGES; i++) begin
          stg_q[i] <= stg_q[i-1];
        end
      end
    end

    assign q = stg_q[STAGES-1];
  end

endmodule

// File: rtl/cmd_handshake.sv
module cmd_handshake #(
  parameter int CMD_W = 8,
  localparam int CNT_W = CMD_W - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CMD_W-1:0] cmd_word_i,
  input  logic             strobe_i,
  input  logic             clear_i,
  input  logic             step_fall_i,
  output logic             load_o,
  output logic [CNT_W-1:0] load_cnt_o,
  output logic             load_dir_o,
  output logic             ack_o
);

  logic             strobe_d, clear_d;
  logic             strobe_rise, clear_rise;
  logic [CMD_W-1:0] instr_q;
  logic             arm_q, ack_q, pend_q;

  assign strobe_rise = strobe_i & ~strobe_d;
  assign clear_rise  = clear_i  & ~clear_d;

  // One load per handshake: armed, not yet acknowledged, step clock falling
  assign load_o     = arm_q & ~ack_q & step_fall_i;
  assign load_cnt_o = instr_q[CNT_W-1:0];
  assign load_dir_o = instr_q[CMD_W-1];
  assign ack_o      = ack_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      strobe_d <= 1'b0;
      clear_d  <= 1'b0;
      instr_q  <= '0;
      arm_q    <= 1'b0;
      ack_q    <= 1'b0;
      pend_q   <= 1'b0;
    end else begin
      strobe_d <= strobe_i;
      clear_d  <= clear_i;
      if (strobe_rise) begin
        instr_q <= cmd_word_i;
      end
      if (clear_rise) begin
        // a command posted during the acknowledge keeps the block armed
        ack_q  <= 1'b0;
        arm_q  <= pend_q | strobe_rise;
        pend_q <= 1'b0;
      end else begin
        if (load_o) begin
          ack_q <= 1'b1;
        end
        if (strobe_rise) begin
          if (ack_q || load_o) begin
            pend_q <= 1'b1;
          end else begin
            arm_q <= 1'b1;
          end
        end
      end
    end
  end

  assert_ack_clear_R4: assert property (@(posedge clk) disable iff (rst)
    clear_rise |=> !ack_q);

  assert_ack_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    (ack_q && !clear_rise) |=> ack_q);

  assert_ack_needs_arm_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(ack_q) |-> $past(arm_q));

  assert_no_load_while_ack_R5: assert property (@(posedge clk) disable iff (rst)
    ack_q |-> !load_o);

endmodule

// File: rtl/step_down_counter.sv
module step_down_counter #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_cnt_i,
  input  logic             load_dir_i,
  input  logic             step_rise_i,
  output logic             dir_o,
  output logic             step_pulse_o,
  output logic             done_o
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             dec;

  assign dec = step_rise_i & ~load_i & (cnt_q != '0);

  always_comb begin
    if (load_i) begin
      cnt_nxt = load_cnt_i;
    end else if (dec) begin
      cnt_nxt = cnt_q - ONE;
    end else begin
      cnt_nxt = cnt_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q        <= '0;
      dir_o        <= 1'b0;
      step_pulse_o <= 1'b0;
      done_o       <= 1'b1;
    end else begin
      cnt_q        <= cnt_nxt;
      step_pulse_o <= dec;
      done_o       <= (cnt_nxt == '0);
      if (load_i) begin
        dir_o <= load_dir_i;
      end
    end
  end

  assert_no_underflow_R6: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == '0 && !load_i) |=> (cnt_q == '0));

  assert_step_dec_R6: assert property (@(posedge clk) disable iff (rst)
    step_pulse_o |-> (cnt_q == $past(cnt_q) - ONE));

  assert_done_holds_R7: assert property (@(posedge clk) disable iff (rst)
    (done_o && !load_i) |=> done_o);

endmodule

// File: rtl/sense_capture.sv
module sense_capture (
  input  logic clk,
  input  logic rst,
  input  logic drop_i,
  input  logic drop_clr_i,
  input  logic button_i,
  output logic drop_flag_o,
  output logic ready_o
);

  logic drop_d, dclr_d, flag_q, ready_q;
  logic drop_rise, dclr_rise;

  assign drop_rise = drop_i & ~drop_d;
  assign dclr_rise = drop_clr_i & ~dclr_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      drop_d  <= 1'b0;
      dclr_d  <= 1'b0;
      flag_q  <= 1'b0;
      ready_q <= 1'b0;
    end else begin
      drop_d  <= drop_i;
      dclr_d  <= drop_clr_i;
      ready_q <= button_i;
      // a new drop wins over a clear in the same cycle
      if (drop_rise) begin
        flag_q <= 1'b1;
      end else if (dclr_rise) begin
        flag_q <= 1'b0;
      end
    end
  end

  assign drop_flag_o = flag_q & ~rst;
  assign ready_o     = ready_q & ~rst;

  assert_drop_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !dclr_rise) |=> flag_q);

  assert_drop_cause_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_q) |-> $past(drop_rise));

endmodule

// File: rtl/step_cmd_ctrl.sv
module step_cmd_ctrl
  import step_pkg::*;
#(
  parameter int CMD_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CMD_W-1:0] cmd_word,
  input  logic             cmd_strobe,
  input  logic             ack_clear,
  input  logic             step_clk,
  input  logic             drop_sense,
  input  logic             drop_clear,
  input  logic             button,
  output logic             motor_dir,
  output logic             step_pulse,
  output logic             load_ack,
  output logic             run_done,
  output logic             drop_flag,
  output logic             patient_ready
);

  localparam int CNT_W = CMD_W - 1;

  host_in_t              raw_in, syn_in;
  logic [HOST_IN_W-1:0]  syn_bits;
  logic                  sclk_d, step_fall, step_rise;
  logic                  load;
  logic [CNT_W-1:0]      load_cnt;
  logic                  load_dir;

  assign raw_in.cmd_strobe = cmd_strobe;
  assign raw_in.ack_clear  = ack_clear;
  assign raw_in.step_clk   = step_clk;
  assign raw_in.drop_sense = drop_sense;
  assign raw_in.drop_clear = drop_clear;
  assign raw_in.button     = button;

  sync_bits #(.W(HOST_IN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw_in),
    .q   (syn_bits)
  );

  assign syn_in = host_in_t'(syn_bits);

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d <= 1'b0;
    end else begin
      sclk_d <= syn_in.step_clk;
    end
  end

  assign step_fall = sclk_d & ~syn_in.step_clk;
  assign step_rise = ~sclk_d & syn_in.step_clk;

  cmd_handshake #(.CMD_W(CMD_W)) u_hs (
    .clk         (clk),
    .rst         (rst),
    .cmd_word_i  (cmd_word),
    .strobe_i    (syn_in.cmd_strobe),
    .clear_i     (syn_in.ack_clear),
    .step_fall_i (step_fall),
    .load_o      (load),
    .load_cnt_o  (load_cnt),
    .load_dir_o  (load_dir),
    .ack_o       (load_ack)
  );

  step_down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk          (clk),
    .rst          (rst),
    .load_i       (load),
    .load_cnt_i   (load_cnt),
    .load_dir_i   (load_dir),
    .step_rise_i  (step_rise),
    .dir_o        (motor_dir),
    .step_pulse_o (step_pulse),
    .done_o       (run_done)
  );

  sense_capture u_sense (
    .clk         (clk),
    .rst         (rst),
    .drop_i      (syn_in.drop_sense),
    .drop_clr_i  (syn_in.drop_clear),
    .button_i    (syn_in.button),
    .drop_flag_o (drop_flag),
    .ready_o     (patient_ready)
  );

  assert_load_edge_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(load_ack) |-> $past(step_fall));

endmodule

// File: tb/step_cmd_ctrl_bench.sv
module step_cmd_ctrl_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] cmd_word = '0;
  logic       cmd_strobe = 1'b0, ack_clear = 1'b0, step_clk = 1'b0;
  logic       drop_sense = 1'b0, drop_clear = 1'b0, button = 1'b0;
  logic       motor_dir, step_pulse, load_ack, run_done, drop_flag, patient_ready;

  always #5 clk = ~clk;

  step_cmd_ctrl u_step_cmd_ctrl (
    .clk(clk), .rst(rst), .cmd_word(cmd_word), .cmd_strobe(cmd_strobe),
    .ack_clear(ack_clear), .step_clk(step_clk), .drop_sense(drop_sense),
    .drop_clear(drop_clear), .button(button), .motor_dir(motor_dir),
    .step_pulse(step_pulse), .load_ack(load_ack), .run_done(run_done),
    .drop_flag(drop_flag), .patient_ready(patient_ready)
  );

  typedef struct { int n; bit d; } exp_t;
  exp_t exp_q[$];

  int total = 0, bad = 0, pulses_total = 0;
  bit finished = 1'b0;

  task automatic chk(bit ok, string req, string what, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // free-running step clock, ten system cycles per period
  initial begin
    forever begin
      repeat (5) @(negedge clk);
      step_clk = ~step_clk;
    end
  end

  // monitor: pairs each acknowledge with the oldest queued command
  bit active = 1'b0, ack_prev = 1'b0, run_dir = 1'b0;
  int run_n = 0;
  always @(negedge clk) begin
    if (rst) begin
      active = 1'b0;
      ack_prev = 1'b0;
    end else begin
      if (step_pulse) pulses_total++;
      if (step_pulse && !active) chk(1'b0, "R6", "stray step pulse", 1, 0);
      if (load_ack && !ack_prev) begin
        active = 1'b1;
        run_n = 0;
        run_dir = motor_dir;
      end
      if (active && step_pulse) run_n++;
      if (active && run_done) begin
        active = 1'b0;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R5", "load with no command queued", 1, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(run_n == e.n, "R6", "pulses per command", run_n, e.n);
          chk(run_dir == e.d, "R1", "direction bit", run_dir, e.d);
        end
      end
      ack_prev = load_ack;
    end
  end

  task automatic strobe_cmd(input logic [7:0] w);
    exp_t e;
    e.n = w[6:0];
    e.d = w[7];
    exp_q.push_back(e);
    @(negedge clk);
    cmd_word = w;
    cmd_strobe = 1'b1;
    repeat (2) @(negedge clk);
    cmd_strobe = 1'b0;
  endtask

  task automatic wait_ack(string req);
    int k;
    k = 0;
    while (!load_ack && k < 100) begin
      @(negedge clk);
      k++;
    end
    chk(load_ack, req, "load_ack raised", load_ack, 1);
  endtask

  task automatic wait_idle(string req);
    int k;
    k = 0;
    while ((exp_q.size() != 0 || !run_done) && k < 3000) begin
      @(negedge clk);
      k++;
    end
    chk(exp_q.size() == 0, req, "commands left unmatched", exp_q.size(), 0);
  endtask

  task automatic pulse_clear();
    @(negedge clk);
    ack_clear = 1'b1;
    repeat (2) @(negedge clk);
    ack_clear = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      chk(1'b0, "ALL", "watchdog expired", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    int p;
    bit dropped;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(run_done == 1'b1,   "R11", "run_done after reset", run_done, 1);
    chk(load_ack == 1'b0,   "R11", "load_ack after reset", load_ack, 0);
    chk(step_pulse == 1'b0, "R11", "step_pulse after reset", step_pulse, 0);
    chk(motor_dir == 1'b0,  "R11", "motor_dir after reset", motor_dir, 0);
    chk(drop_flag == 1'b0,  "R11", "drop_flag after reset", drop_flag, 0);

    // R2 no load without a strobe
    repeat (40) @(negedge clk);
    chk(load_ack == 1'b0, "R2", "no load without strobe", load_ack, 0);

    // R1 R3 R6 direction 1, five steps
    strobe_cmd(8'h85);
    wait_ack("R3");
    wait_idle("R6");
    // R5 acknowledge held: no reload
    p = pulses_total;
    repeat (40) @(negedge clk);
    chk(pulses_total == p, "R5", "no pulses while acknowledged", pulses_total - p, 0);
    chk(load_ack == 1'b1,  "R5", "load_ack held", load_ack, 1);
    chk(run_done == 1'b1,  "R7", "run_done at zero", run_done, 1);
    pulse_clear();
    chk(load_ack == 1'b0, "R4", "load_ack cleared", load_ack, 0);
    repeat (40) @(negedge clk);
    chk(load_ack == 1'b0, "R2", "no reload after clear", load_ack, 0);

    // direction 0, three steps
    strobe_cmd(8'h03);
    wait_ack("R3");
    wait_idle("R6");
    pulse_clear();

    // R7 zero-count command
    p = pulses_total;
    dropped = 1'b0;
    strobe_cmd(8'h80);
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (!run_done) dropped = 1'b1;
    end
    chk(load_ack == 1'b1,  "R7", "zero count acknowledged", load_ack, 1);
    chk(dropped == 1'b0,   "R7", "run_done dropped on zero count", dropped, 0);
    chk(pulses_total == p, "R7", "pulses on zero count", pulses_total - p, 0);
    wait_idle("R7");
    pulse_clear();

    // R5 strobe during acknowledge is held until the clear
    strobe_cmd(8'h0A);
    wait_ack("R3");
    wait_idle("R6");
    strobe_cmd(8'h04);
    p = pulses_total;
    repeat (40) @(negedge clk);
    chk(pulses_total == p, "R5", "posted word not loaded early", pulses_total - p, 0);
    pulse_clear();
    wait_idle("R5");
    pulse_clear();

    // full scale count, direction 1
    strobe_cmd(8'hFF);
    wait_ack("R3");
    wait_idle("R6");
    pulse_clear();

    // R8 drop flag
    @(negedge clk);
    drop_sense = 1'b1;
    repeat (2) @(negedge clk);
    drop_sense = 1'b0;
    repeat (6) @(negedge clk);
    chk(drop_flag == 1'b1, "R8", "drop flag set", drop_flag, 1);
    repeat (20) @(negedge clk);
    chk(drop_flag == 1'b1, "R8", "drop flag sticky", drop_flag, 1);
    drop_clear = 1'b1;
    repeat (2) @(negedge clk);
    drop_clear = 1'b0;
    repeat (6) @(negedge clk);
    chk(drop_flag == 1'b0, "R8", "drop flag cleared", drop_flag, 0);

    // R10 button relay
    button = 1'b1;
    repeat (6) @(negedge clk);
    chk(patient_ready == 1'b1, "R10", "ready follows button", patient_ready, 1);
    drop_sense = 1'b1;
    repeat (6) @(negedge clk);
    chk(drop_flag == 1'b1, "R8", "drop flag set again", drop_flag, 1);

    // R9 gating under reset
    rst = 1'b1;
    #1;
    chk(drop_flag == 1'b0,     "R9", "drop_flag in reset", drop_flag, 0);
    chk(patient_ready == 1'b0, "R9", "patient_ready in reset", patient_ready, 0);
    repeat (3) @(negedge clk);
    chk(drop_flag == 1'b0,     "R9", "drop_flag held in reset", drop_flag, 0);
    chk(patient_ready == 1'b0, "R9", "patient_ready held in reset", patient_ready, 0);
    drop_sense = 1'b0;
    rst = 1'b0;
    repeat (6) @(negedge clk);
    chk(patient_ready == 1'b1, "R10", "ready after reset", patient_ready, 1);
    chk(drop_flag == 1'b0,     "R11", "drop_flag after second reset", drop_flag, 0);

    if (!finished) begin
      finished = 1'b1;
      summary();
      $finish;
    end
  end

endmodule